// File: doc/BRIEF.md
# Tile Row Replay Controller

This block feeds tile descriptors to a video fetch engine. A main store holds 240 descriptor words of 14 bits. A line buffer holds 20 entries. Each rising edge of a fetch strobe puts one descriptor on the output bus. On the first scanline of a tile row the block reads 20 new descriptors from the main store and also captures them into the line buffer. On the next 15 scanlines it plays that buffer again.

The block moves to a new tile row only when three conditions hold at the same time: the scanline counter is 0, the line index is 0, and the host bus-acknowledge input is low. In every other case the previous row plays again. So an acknowledge that comes early or late repeats a whole row and never shifts cards sideways. An interrupt-acknowledge pulse rewinds the block to the top of the field. While display is inactive, the block passes host data straight through and the host may load the main store. The first falling edge of bus acknowledge starts display.

Top module: `tilerow_replay`

## Requirements
- R1: After a synchronous reset, `desc_out` is 0 and both `disp_active` and `fetch_mode` are 0.
- R2: While `disp_active` is 0, `desc_out` shows `host_data` one clock later, and fetch strobes change no index.
- R3: A falling edge on `busack_n` that is not paired with `intack` sets `disp_active` on the next clock.
- R4: When display is active and the block is in fetch mode, a rising strobe drives `desc_out` with store[storage index] one clock later. The same word is written to linebuf[line index], and both indices advance.
- R5: When display is active and the block is in replay mode, a rising strobe drives `desc_out` with linebuf[line index], and only the line index advances.
- R6: After line index 19 the line index returns to 0 and the 4-bit scanline counter advances modulo 16. `fetch_mode` then becomes 1 only if the new count is 0 and `busack_n` is low.
- R7: Fetch mode also begins in any active cycle where `busack_n` is low and both counters are 0. Without that condition the last fetched row plays again for as long as the condition stays false.
- R8: An `intack` pulse clears `disp_active`, `fetch_mode`, the storage index, the line index and the scanline counter.
- R9: The storage index stops at 240. A fetch made at that point outputs 0.
- R10: A host write with `host_we` high stores `host_data` at `host_addr` only while display is inactive and the address is below 240. Writes made during display are ignored.
- R11: With `busack_n` held low from the start of display, 3840 strobes read all 240 stored descriptors in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intack | input | 1 | Interrupt-acknowledge pulse; rewinds to the top of the field |
| busack_n | input | 1 | Host bus acknowledge, active low (level) |
| fetch_strobe | input | 1 | Fetch strobe; each rising edge serves one descriptor |
| host_we | input | 1 | Host store write enable |
| host_addr | input | 8 | Host store write address |
| host_data | input | 14 | Host data: pass-through source and write data |
| desc_out | output | 14 | Descriptor bus |
| disp_active | output | 1 | 1 while display is active; 0 in host copy mode |
| fetch_mode | output | 1 | 1 when the next strobes fetch a new row |

## Verification
The bench builds the block with its default sizes: 240 descriptors, rows of 20, 16 lines per row and 14-bit words. With these sizes a full 3840-strobe pass and the stop at index 240 both fit in a short run. Directed phases cover these cases:
- acknowledge held low;
- acknowledge raised so that a row repeats;
- acknowledge lowered in the middle of a row;
- a rewind by interrupt acknowledge.

A random phase mixes acknowledge toggles, idle cycles, host writes and strobes.

// File: rtl/tilerow_pkg.sv
package tilerow_pkg;

    localparam int TR_DESC_COUNT = 240;
    localparam int TR_ROW_LEN    = 20;
    localparam int TR_ROW_LINES  = 16;
    localparam int TR_DESC_W     = 14;

    typedef enum logic {
        MODE_REPLAY = 1'b0,
        MODE_FETCH  = 1'b1
    } fill_mode_e;

    typedef struct packed {
        logic fetch;
        logic replay;
    } tile_op_t;

    function automatic logic row_start(input logic ack_n, input logic line_zero,
                                       input logic idx_zero);
        return !ack_n && line_zero && idx_zero;
    endfunction

endpackage

// File: rtl/tr_edge_detect.sv
module tr_edge_detect #(
    parameter logic IDLE    = 1'b0,
    parameter bit   FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic evt
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= IDLE;
        else     sig_q <= sig;
    end

    generate
        if (FALLING) begin : g_fall
            assign evt = sig_q && !sig;
        end else begin : g_rise
            assign evt = !sig_q && sig;
        end
    endgenerate
endmodule

// File: rtl/tr_ram.sv
module tr_ram #(
    parameter int DEPTH = 20,
    parameter int W     = 14,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) cells[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? cells[raddr] : '0;
endmodule

// File: rtl/tr_sequencer.sv
module tr_sequencer
    import tilerow_pkg::*;
#(
    parameter int N_DESC    = TR_DESC_COUNT,
    parameter int ROW_LEN   = TR_ROW_LEN,
    parameter int ROW_LINES = TR_ROW_LINES,
    parameter int LW        = $clog2(ROW_LEN),
    parameter int SW        = $clog2(ROW_LINES),
    parameter int XW        = $clog2(N_DESC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          intack,
    input  logic          busack_n,
    input  logic          ack_fall,
    input  logic          strobe_rise,
    output logic          disp_active,
    output logic          fetch_mode,
    output logic [LW-1:0] lidx,
    output logic [SW-1:0] scnt,
    output logic [XW-1:0] sidx,
    output tile_op_t      op
);
    fill_mode_e    mode_q;
    logic          disp_q;
    logic [LW-1:0] lidx_q;
    logic [SW-1:0] scnt_q;
    logic [XW-1:0] sidx_q;

    logic          start_ok;
    logic          eff_fetch;
    logic          lidx_last;
    logic [SW-1:0] scnt_nxt;

    assign start_ok  = row_start(busack_n, scnt_q == '0, lidx_q == '0);
    assign eff_fetch = (mode_q == MODE_FETCH) || start_ok;
    assign lidx_last = (lidx_q == LW'(ROW_LEN - 1));
    assign scnt_nxt  = (scnt_q == SW'(ROW_LINES - 1)) ? '0 : scnt_q + SW'(1);

    assign op.fetch  = disp_q && !intack && strobe_rise && eff_fetch;
    assign op.replay = disp_q && !intack && strobe_rise && !eff_fetch;

    always_ff @(posedge clk) begin
        if (rst || intack) begin
            disp_q <= 1'b0;
            mode_q <= MODE_REPLAY;
            lidx_q <= '0;
            scnt_q <= '0;
            sidx_q <= '0;
        end else begin
            if (ack_fall) disp_q <= 1'b1;
            if (disp_q) begin
                if (op.fetch || op.replay) begin
                    if (op.fetch && (sidx_q < XW'(N_DESC))) sidx_q <= sidx_q + XW'(1);
                    if (lidx_last) begin
                        lidx_q <= '0;
                        scnt_q <= scnt_nxt;
                        mode_q <= ((scnt_nxt == '0) && !busack_n) ? MODE_FETCH : MODE_REPLAY;
                    end else begin
                        lidx_q <= lidx_q + LW'(1);
                        mode_q <= eff_fetch ? MODE_FETCH : MODE_REPLAY;
                    end
                end else begin
                    mode_q <= eff_fetch ? MODE_FETCH : MODE_REPLAY;
                end
            end
        end
    end

    assign disp_active = disp_q;
    assign fetch_mode  = (mode_q == MODE_FETCH);
    assign lidx        = lidx_q;
    assign scnt        = scnt_q;
    assign sidx        = sidx_q;
endmodule

// File: rtl/tilerow_replay.sv
module tilerow_replay
    import tilerow_pkg::*;
#(
    parameter int N_DESC    = TR_DESC_COUNT,
    parameter int ROW_LEN   = TR_ROW_LEN,
    parameter int ROW_LINES = TR_ROW_LINES,
    parameter int DW        = TR_DESC_W,
    parameter int LW        = $clog2(ROW_LEN),
    parameter int SW        = $clog2(ROW_LINES),
    parameter int XW        = $clog2(N_DESC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          intack,
    input  logic          busack_n,
    input  logic          fetch_strobe,
    input  logic          host_we,
    input  logic [XW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    output logic [DW-1:0] desc_out,
    output logic          disp_active,
    output logic          fetch_mode
);
    logic          ack_fall;
    logic          strobe_rise;
    logic [LW-1:0] lidx_w;
    logic [SW-1:0] scnt_w;
    logic [XW-1:0] sidx_w;
    tile_op_t      op_w;
    logic [DW-1:0] store_rd;
    logic [DW-1:0] line_rd;
    logic [DW-1:0] out_q;

    tr_edge_detect #(.IDLE(1'b1), .FALLING(1'b1)) u_ack_edge (
        .clk(clk), .rst(rst), .sig(busack_n), .evt(ack_fall)
    );

    tr_edge_detect #(.IDLE(1'b0), .FALLING(1'b0)) u_strobe_edge (
        .clk(clk), .rst(rst), .sig(fetch_strobe), .evt(strobe_rise)
    );

    tr_sequencer #(
        .N_DESC(N_DESC), .ROW_LEN(ROW_LEN), .ROW_LINES(ROW_LINES),
        .LW(LW), .SW(SW), .XW(XW)
    ) u_seq (
        .clk(clk), .rst(rst), .intack(intack), .busack_n(busack_n),
        .ack_fall(ack_fall), .strobe_rise(strobe_rise),
        .disp_active(disp_active), .fetch_mode(fetch_mode),
        .lidx(lidx_w), .scnt(scnt_w), .sidx(sidx_w), .op(op_w)
    );

    tr_ram #(.DEPTH(N_DESC), .W(DW), .AW(XW)) u_store (
        .clk(clk), .we(host_we && !disp_active), .waddr(host_addr),
        .wdata(host_data), .raddr(sidx_w), .rdata(store_rd)
    );

    tr_ram #(.DEPTH(ROW_LEN), .W(DW), .AW(LW)) u_linebuf (
        .clk(clk), .we(op_w.fetch), .waddr(lidx_w),
        .wdata(store_rd), .raddr(lidx_w), .rdata(line_rd)
    );

    always_ff @(posedge clk) begin
        if (rst)              out_q <= '0;
        else if (intack)      out_q <= out_q;
        else if (!disp_active) out_q <= host_data;
        else if (op_w.fetch)  out_q <= store_rd;
        else if (op_w.replay) out_q <= line_rd;
    end

    assign desc_out = out_q;
endmodule

// File: rtl/tilerow_replay_chk.sv
module tilerow_replay_chk #(
    parameter int N_DESC  = 240,
    parameter int ROW_LEN = 20,
    parameter int LW      = 5,
    parameter int SW      = 4,
    parameter int XW      = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          intack,
    input logic          busack_n,
    input logic          disp_active,
    input logic          fetch_mode,
    input logic [LW-1:0] lidx,
    input logic [SW-1:0] scnt,
    input logic [XW-1:0] sidx
);
    AST_LIDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        lidx < LW'(ROW_LEN)); // R6

    AST_SIDX_SATURATE: assert property (@(posedge clk) disable iff (rst)
        sidx <= XW'(N_DESC)); // R9

    AST_INTACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        intack |=> (!disp_active && !fetch_mode && lidx == '0 && scnt == '0 && sidx == '0)); // R8

    AST_ACK_FALL_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!intack && $fell(busack_n)) |=> disp_active); // R3

    AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!disp_active && !intack) |=> ($stable(lidx) && $stable(scnt) && $stable(sidx))); // R2

    AST_SCNT_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!intack && lidx != LW'(ROW_LEN - 1)) |=> $stable(scnt)); // R6

    AST_REPLAY_KEEPS_SIDX: assert property (@(posedge clk) disable iff (rst)
        (!intack && !fetch_mode && !(!busack_n && scnt == '0 && lidx == '0)) |=> $stable(sidx)); // R5
endmodule

bind tilerow_replay tilerow_replay_chk #(
    .N_DESC(N_DESC), .ROW_LEN(ROW_LEN), .LW(LW), .SW(SW), .XW(XW)
) u_chk (
    .clk(clk), .rst(rst), .intack(intack), .busack_n(busack_n),
    .disp_active(disp_active), .fetch_mode(fetch_mode),
    .lidx(lidx_w), .scnt(scnt_w), .sidx(sidx_w)
);

// File: tb/tilerow_replay_bench.sv
module tilerow_replay_bench;
    localparam int NDESC = 240;
    localparam int ROWL  = 20;
    localparam int LINES = 16;
    localparam int DW    = 14;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst, intack, busack_n, fetch_strobe, host_we;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_data;
    logic [DW-1:0] desc_out;
    logic          disp_active, fetch_mode;

    always #2 clk = ~clk;

    tilerow_replay u_tilerow_replay (
        .clk(clk), .rst(rst), .intack(intack), .busack_n(busack_n),
        .fetch_strobe(fetch_strobe), .host_we(host_we), .host_addr(host_addr),
        .host_data(host_data), .desc_out(desc_out),
        .disp_active(disp_active), .fetch_mode(fetch_mode)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [DW-1:0] m_mem [NDESC];
    logic [DW-1:0] m_lb [ROWL];
    logic [DW-1:0] m_out;
    int m_sidx, m_lidx, m_scnt, m_fetched;
    bit m_disp, m_fetch, m_prev, m_wrapped;
    string m_tag;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input bit rise);
        bit old_disp;
        bit start, eff;
        old_disp = m_disp;
        m_wrapped = 0;
        m_tag = "R2 pass-through";
        if (host_we && !old_disp && int'(host_addr) < NDESC) m_mem[host_addr] = host_data;
        if (intack) begin
            m_disp = 0; m_fetch = 0; m_sidx = 0; m_lidx = 0; m_scnt = 0;
            m_prev = busack_n;
            return;
        end
        start = !busack_n && m_scnt == 0 && m_lidx == 0;
        eff = m_fetch || start;
        if (!old_disp) begin
            m_out = host_data;
        end else if (rise) begin
            if (eff) begin
                m_tag = (m_sidx == 30) ? "R10 write during display ignored" :
                        (m_sidx >= NDESC) ? "R9 saturated fetch" : "R4 fetch";
                m_out = (m_sidx < NDESC) ? m_mem[m_sidx] : '0;
                m_lb[m_lidx] = m_out;
                if (m_sidx < NDESC) begin m_sidx++; m_fetched++; end
            end else begin
                m_tag = (m_scnt == 0 && busack_n) ? "R7 row repeat" : "R5 replay";
                m_out = m_lb[m_lidx];
            end
            if (m_lidx == ROWL - 1) begin
                m_lidx = 0;
                m_scnt = (m_scnt + 1) % LINES;
                m_fetch = (m_scnt == 0) && !busack_n;
                m_wrapped = 1;
            end else begin
                m_lidx++;
                m_fetch = eff;
            end
        end else begin
            m_fetch = eff;
        end
        if (m_prev && !busack_n) m_disp = 1;
        m_prev = busack_n;
    endtask

    task automatic step();
        @(posedge clk); #1;
        model_edge(0);
    endtask

    task automatic strobe_once();
        fetch_strobe = 1'b1;
        @(posedge clk); #1;
        model_edge(1);
        check_val(m_tag, 32'(desc_out), 32'(m_out));
        if (m_wrapped) check_val("R6 mode after wrap", 32'(fetch_mode), 32'(m_fetch));
        fetch_strobe = 1'b0;
        step();
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        host_we = 1'b1; host_addr = a; host_data = d;
        step();
        host_we = 1'b0;
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd7331);
        rst = 1'b1; intack = 1'b0; busack_n = 1'b1; fetch_strobe = 1'b0;
        host_we = 1'b0; host_addr = '0; host_data = '0;
        m_disp = 0; m_fetch = 0; m_prev = 1; m_sidx = 0; m_lidx = 0; m_scnt = 0;
        m_out = '0; m_fetched = 0;
        for (int i = 0; i < ROWL; i++) m_lb[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_val("R1 desc_out reset", 32'(desc_out), 32'h0);
        check_val("R1 disp_active reset", 32'(disp_active), 32'h0);
        check_val("R1 fetch_mode reset", 32'(fetch_mode), 32'h0);

        for (int i = 0; i < NDESC; i++) host_write(AW'(i), DW'($urandom));
        host_write(8'd245, DW'($urandom));

        for (int k = 0; k < 6; k++) begin
            host_data = DW'($urandom);
            step();
            check_val("R2 pass-through", 32'(desc_out), 32'(host_data));
        end
        strobe_once();
        strobe_once();

        busack_n = 1'b0;
        step();
        check_val("R3 display starts", 32'(disp_active), 32'h1);

        for (int i = 0; i < ROWL; i++) strobe_once();
        host_write(8'd30, ~m_mem[30]);
        for (int i = 0; i < 320; i++) strobe_once();

        busack_n = 1'b1;
        step();
        for (int i = 0; i < 700; i++) strobe_once();

        while (m_scnt != 5) strobe_once();
        busack_n = 1'b0;
        step();
        for (int i = 0; i < 400; i++) strobe_once();

        for (int i = 0; i < 1500; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) begin busack_n = ~busack_n; step(); end
            else if (r == 1) step();
            else if (r == 2) host_write(AW'($urandom), DW'($urandom));
            else strobe_once();
        end

        intack = 1'b1;
        step();
        intack = 1'b0;
        check_val("R8 display cleared", 32'(disp_active), 32'h0);
        check_val("R8 fetch mode cleared", 32'(fetch_mode), 32'h0);
        host_data = DW'($urandom);
        step();
        check_val("R8 back to pass-through", 32'(desc_out), 32'(host_data));
        busack_n = 1'b1;
        step();
        busack_n = 1'b0;
        step();
        m_fetched = 0;
        strobe_once();
        check_val("R8 rewound to first word", 32'(desc_out), 32'(m_mem[0]));
        for (int i = 1; i < NDESC * LINES; i++) strobe_once();
        check_val("R11 all descriptors read", 32'(m_fetched), 32'(NDESC));
        strobe_once();
        check_val("R9 saturated fetch is zero", 32'(desc_out), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule